// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Unit

This block holds the interrupt state that processors in a small multiprocessor use to signal each other and to take periodic timer interrupts. It supports one to four processors. For each processor it keeps one interprocessor-interrupt (IPI) pending bit and one timer-interrupt pending bit. Each pending bit drives a level output for its processor: `ipi_irq` is the level-3 line and `tmr_irq` is the level-2 line.

Software works the block through register writes. A shared control register carries three independent 4-bit processor masks: raise IPIs, drop IPIs and drop timer interrupts. All three can act in one write. Three dedicated registers each do one of these jobs, using a mask in the low nibble. An external tick pulse from a separate interval timer raises the timer interrupt on every present processor. If a write asks for something that is already true, the block raises a warning pulse. If a write has no effect at all, the block raises an error pulse. Reads are combinational and return the pending vectors and the number of the processor that is reading.

Top module: `itu_irq_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, all IPI and timer pending bits are zero, and `warn` and `err` are low.
- R2: A write with `wr_sel`=0 (control register) acts on three masks. Bits 15:12 raise IPIs, bits 11:8 drop IPIs and bits 7:4 drop timer interrupts. Every nonzero field acts in that same write. The request is applied before the drop, so a processor named in both fields ends with no IPI pending.
- R3: `warn` pulses high if the write does either of these: raises an IPI for a present processor whose IPI is already pending, or drops an IPI for a present processor that is not pending even after that write's requests. The warning leaves the state as if the duplicate part were absent.
- R4: When `tick` is high at a clock edge, the timer pending bit of every present processor is set. This holds even if the same write drops that bit.
- R5: Dedicated registers take their mask from `wr_data[3:0]`. `wr_sel`=1 drops IPIs, `wr_sel`=2 drops timer interrupts and `wr_sel`=3 raises IPIs.
- R6: A control-register write in which bits 15:4 and bit 28 are all zero is an error. It pulses `err` and changes nothing. If bit 28 is set and the three masks are zero, the write is accepted with no error and no state change.
- R7: A dedicated-register write with `wr_data[3:0]`=0 pulses `err` and changes nothing.
- R8: `rd_data` is combinational.
  - With `rd_sel`=0 it returns `rd_cpu` in bits 1:0, timer pending in bits 7:4 and IPI pending in bits 11:8.
  - With `rd_sel`=1 it returns IPI pending in the low bits.
  - With `rd_sel`=2 it returns timer pending in the low bits.
  - With `rd_sel`=3 it returns zero.
  - All other bits read as zero.
- R9: Parameter `NCPU` (1 to 4) sets the number of present processors. Mask bits at positions `NCPU` and above have no effect and cause no warning. A mask that is nonzero only in those bits still counts as nonzero for R6 and R7.
- R10: `warn` and `err` are registered, one-cycle pulses in the cycle after the write. A cycle with no write leaves them low and leaves the IPI state unchanged. `warn` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 IPI drop, 2 timer drop, 3 IPI raise |
| wr_data | input | DATA_W | Write data |
| tick | input | 1 | Interval timer pulse |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_cpu | input | 2 | Number of the processor performing the read |
| rd_data | output | DATA_W | Read data |
| ipi_irq | output | NCPU | Level-3 interrupt per processor (IPI pending) |
| tmr_irq | output | NCPU | Level-2 interrupt per processor (timer pending) |
| warn | output | 1 | Pulse: redundant raise or drop of an IPI |
| err | output | 1 | Pulse: write that names no action |

## Verification
The properties assume that `wr_sel`, `wr_en`, `wr_data` and `tick` are known after reset and settle before each rising edge. The stimulus meets this by changing these inputs only on falling edges. The properties also take the request-before-drop ordering and the tick-wins rule as given. They therefore check only the consequences that hold under every combination, for example that a tick leaves every timer bit set and that an idle cycle keeps the IPI state. The stimulus sweeps every combination of the three control masks from a drifting pending state, with tick and the bit-28 acknowledge mixed in, and then sweeps every mask on each dedicated register. A second instance with two processors receives the same stimulus.

// File: rtl/itu_pkg.sv
package itu_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_IPI_CLR = 2'd1,
      SEL_TMR_CLR = 2'd2,
      SEL_IPI_REQ = 2'd3
   } itu_sel_e;

   localparam int unsigned MASK_W   = 4;
   localparam int unsigned REQ_LSB  = 12;
   localparam int unsigned ICLR_LSB = 8;
   localparam int unsigned TCLR_LSB = 4;
   localparam int unsigned ACK_BIT  = 28;
   localparam int unsigned MIN_DW   = 32;

   typedef struct packed {
      logic [MASK_W-1:0] req;
      logic [MASK_W-1:0] iclr;
      logic [MASK_W-1:0] tclr;
      logic              err;
   } itu_cmd_t;

endpackage

// File: rtl/itu_decode.sv
module itu_decode
   import itu_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output itu_cmd_t          cmd
);

   logic [MASK_W-1:0] low_m;
   logic              ack;
   logic              unused_bits;

   assign low_m       = wr_data[MASK_W-1:0];
   assign ack         = wr_data[ACK_BIT];
   assign unused_bits = ^{wr_data[DATA_W-1:ACK_BIT+1], wr_data[ACK_BIT-1:REQ_LSB+MASK_W]};

   always_comb begin
      cmd = '0;
      if (wr_en) begin
         case (itu_sel_e'(wr_sel))
            SEL_CTRL: begin
               cmd.req  = wr_data[REQ_LSB  +: MASK_W];
               cmd.iclr = wr_data[ICLR_LSB +: MASK_W];
               cmd.tclr = wr_data[TCLR_LSB +: MASK_W];
               cmd.err  = ~(|wr_data[REQ_LSB  +: MASK_W] | |wr_data[ICLR_LSB +: MASK_W] |
                            |wr_data[TCLR_LSB +: MASK_W] | ack);
            end
            SEL_IPI_CLR: begin
               cmd.iclr = low_m;
               cmd.err  = ~|low_m;
            end
            SEL_TMR_CLR: begin
               cmd.tclr = low_m;
               cmd.err  = ~|low_m;
            end
            default: begin
               cmd.req  = low_m;
               cmd.err  = ~|low_m;
            end
         endcase
      end
   end

endmodule

// File: rtl/itu_pend_bank.sv
module itu_pend_bank #(
   parameter int unsigned NCPU     = 4,
   parameter bit          SET_WINS = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCPU-1:0] set_m,
   input  logic [NCPU-1:0] clr_m,
   output logic [NCPU-1:0] pend
);

   logic [NCPU-1:0] pend_nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         assign pend_nxt = (pend & ~clr_m) | set_m;
      end else begin : g_clr_wins
         assign pend_nxt = (pend | set_m) & ~clr_m;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end

endmodule

// File: rtl/itu_readmux.sv
module itu_readmux
   import itu_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 64
) (
   input  logic [1:0]        rd_sel,
   input  logic [1:0]        rd_cpu,
   input  logic [NCPU-1:0]   ipi,
   input  logic [NCPU-1:0]   tmr,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      rd_data = '0;
      case (itu_sel_e'(rd_sel))
         SEL_CTRL: begin
            rd_data[1:0]               = rd_cpu;
            rd_data[TCLR_LSB +: NCPU]  = tmr;
            rd_data[ICLR_LSB +: NCPU]  = ipi;
         end
         SEL_IPI_CLR: rd_data[NCPU-1:0] = ipi;
         SEL_TMR_CLR: rd_data[NCPU-1:0] = tmr;
         default:     rd_data = '0;
      endcase
   end

endmodule

// File: rtl/itu_irq_unit.sv
module itu_irq_unit
   import itu_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  logic [1:0]        rd_sel,
   input  logic [1:0]        rd_cpu,
   output logic [DATA_W-1:0] rd_data,
   output logic [NCPU-1:0]   ipi_irq,
   output logic [NCPU-1:0]   tmr_irq,
   output logic              warn,
   output logic              err
);

   localparam logic [NCPU-1:0] ALL_PRESENT = {NCPU{1'b1}};

   generate
      if (NCPU < 1 || NCPU > MASK_W) begin : g_bad_ncpu
         $error("itu_irq_unit: NCPU must lie between 1 and 4");
      end
      if (DATA_W < MIN_DW) begin : g_bad_dw
         $error("itu_irq_unit: DATA_W must be at least 32");
      end
   endgenerate

   itu_cmd_t        cmd;
   logic [NCPU-1:0] req_m, iclr_m, tclr_m;
   logic            dup_req, idle_clr;

   itu_decode #(.DATA_W(DATA_W)) u_dec (
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .cmd    (cmd)
   );

   assign req_m  = cmd.req[NCPU-1:0];
   assign iclr_m = cmd.iclr[NCPU-1:0];
   assign tclr_m = cmd.tclr[NCPU-1:0];

   itu_pend_bank #(.NCPU(NCPU), .SET_WINS(1'b0)) u_ipi (
      .clk  (clk),
      .rst_n(rst_n),
      .set_m(req_m),
      .clr_m(iclr_m),
      .pend (ipi_irq)
   );

   itu_pend_bank #(.NCPU(NCPU), .SET_WINS(1'b1)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .set_m(tick ? ALL_PRESENT : '0),
      .clr_m(tclr_m),
      .pend (tmr_irq)
   );

   assign dup_req  = |(req_m & ipi_irq);
   assign idle_clr = |(iclr_m & ~(ipi_irq | req_m));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn <= 1'b0;
         err  <= 1'b0;
      end else begin
         warn <= dup_req | idle_clr;
         err  <= cmd.err;
      end
   end

   itu_readmux #(.NCPU(NCPU), .DATA_W(DATA_W)) u_rd (
      .rd_sel (rd_sel),
      .rd_cpu (rd_cpu),
      .ipi    (ipi_irq),
      .tmr    (tmr_irq),
      .rd_data(rd_data)
   );

endmodule

// File: rtl/itu_irq_chk.sv
module itu_irq_chk #(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              tick,
   input logic [NCPU-1:0]   ipi_irq,
   input logic [NCPU-1:0]   tmr_irq,
   input logic              warn,
   input logic              err
);

   // R5
   ipi_req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && wr_data[3:0] != 4'd0)
      |=> ((ipi_irq & $past(wr_data[NCPU-1:0])) == $past(wr_data[NCPU-1:0])));

   // R5
   tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !tick)
      |=> ((tmr_irq & $past(wr_data[NCPU-1:0])) == '0));

   // R4
   tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (tmr_irq == {NCPU{1'b1}}));

   // R2
   ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0)
      |=> ((ipi_irq & $past(wr_data[8 +: NCPU])) == '0));

   // R7
   zero_mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != 2'd0 && wr_data[3:0] == 4'd0) |=> err);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!warn && !err && $stable(ipi_irq)));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({warn, err}));

endmodule

bind itu_irq_unit itu_irq_chk #(.NCPU(NCPU), .DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .wr_data(wr_data),
   .tick   (tick),
   .ipi_irq(ipi_irq),
   .tmr_irq(tmr_irq),
   .warn   (warn),
   .err    (err)
);

// File: tb/tb_itu_irq_unit.sv
module tb_itu_irq_unit;

   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic          tick = 1'b0;
   logic [1:0]    rd_sel = '0;
   logic [1:0]    rd_cpu = '0;

   logic [DW-1:0] rd_a, rd_b;
   logic [3:0]    ipi_a, tmr_a;
   logic [1:0]    ipi_b, tmr_b;
   logic          warn_a, err_a, warn_b, err_b;

   int nchk = 0;
   int nerr = 0;

   // model state: index 0 = four CPUs, index 1 = two CPUs
   logic [3:0] m_ipi [2];
   logic [3:0] m_tmr [2];
   logic       m_warn [2];
   logic       m_err [2];
   logic [3:0] pm [2];

   always #2 clk = ~clk;

   itu_irq_unit #(.NCPU(4), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tick(tick), .rd_sel(rd_sel), .rd_cpu(rd_cpu), .rd_data(rd_a),
      .ipi_irq(ipi_a), .tmr_irq(tmr_a), .warn(warn_a), .err(err_a)
   );

   itu_irq_unit #(.NCPU(2), .DATA_W(DW)) dut_small (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tick(tick), .rd_sel(rd_sel), .rd_cpu(rd_cpu), .rd_data(rd_b),
      .ipi_irq(ipi_b), .tmr_irq(tmr_b), .warn(warn_b), .err(err_b)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rd_exp(input logic [3:0] ipi, input logic [3:0] tmr,
                                          input logic [1:0] sel, input logic [1:0] cpu);
      logic [63:0] r = '0;
      case (sel)
         2'd0: r = {52'd0, ipi, tmr, 2'b00, cpu};
         2'd1: r = {60'd0, ipi};
         2'd2: r = {60'd0, tmr};
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic model(input int k, input logic [1:0] sel, input logic [63:0] d, input logic tk);
      logic [3:0] req = '0, iclr = '0, tclr = '0;
      logic e = 1'b0;
      case (sel)
         2'd0: begin
            req = d[15:12]; iclr = d[11:8]; tclr = d[7:4];
            e = (d[15:4] == 12'd0) && !d[28];
         end
         2'd1: begin iclr = d[3:0]; e = (d[3:0] == 4'd0); end
         2'd2: begin tclr = d[3:0]; e = (d[3:0] == 4'd0); end
         default: begin req = d[3:0]; e = (d[3:0] == 4'd0); end
      endcase
      req &= pm[k]; iclr &= pm[k]; tclr &= pm[k];
      m_warn[k] = |(req & m_ipi[k]) || |(iclr & ~(m_ipi[k] | req));
      m_err[k]  = e;
      m_ipi[k]  = (m_ipi[k] | req) & ~iclr;
      m_tmr[k]  = m_tmr[k] & ~tclr;
      if (tk) m_tmr[k] = m_tmr[k] | pm[k];
   endtask

   // one write, then check both instances and one read view
   task automatic op(input logic [1:0] sel, input logic [63:0] d, input logic tk,
                     input logic [1:0] rs, input logic [1:0] rc);
      string st;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = tk;
      rd_sel = rs; rd_cpu = rc;
      model(0, sel, d, tk);
      model(1, sel, d, tk);
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      st = tk ? "R4" : ((sel == 2'd0) ? "R2" : "R5");
      chk({st, " ipi"}, 64'(ipi_a), 64'(m_ipi[0]));
      chk({st, " tmr"}, 64'(tmr_a), 64'(m_tmr[0]));
      chk("R3 warn", 64'(warn_a), 64'(m_warn[0]));
      chk((sel == 2'd0) ? "R6 err" : "R7 err", 64'(err_a), 64'(m_err[0]));
      chk("R9 small ipi", 64'(ipi_b), 64'(m_ipi[1]));
      chk("R9 small tmr", 64'(tmr_b), 64'(m_tmr[1]));
      chk("R9 small warn", 64'(warn_b), 64'(m_warn[1]));
      chk("R9 small err", 64'(err_b), 64'(m_err[1]));
      #1;
      chk("R8 read", rd_a, rd_exp(m_ipi[0], m_tmr[0], rs, rc));
      chk("R8 small read", rd_b, rd_exp(m_ipi[1], m_tmr[1], rs, rc));
   endtask

   initial begin
      #(4 * 150000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      pm[0] = 4'hF; pm[1] = 4'h3;
      for (int k = 0; k < 2; k++) begin
         m_ipi[k] = '0; m_tmr[k] = '0; m_warn[k] = 1'b0; m_err[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R1 values while reset is held
      chk("R1 ipi in reset", 64'(ipi_a), 64'd0);
      chk("R1 tmr in reset", 64'(tmr_a), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ipi", 64'(ipi_a), 64'd0);
      chk("R1 tmr", 64'(tmr_a), 64'd0);
      chk("R1 flags", 64'({warn_a, err_a, warn_b, err_b}), 64'd0);
      rd_sel = 2'd0; rd_cpu = 2'd3; #1;
      chk("R1 R8 reset read", rd_a, 64'h3);

      // R6 acknowledge bit alone is accepted
      op(2'd0, 64'h1000_0000, 1'b0, 2'd0, 2'd1);
      // R6 empty control write is an error
      op(2'd0, 64'h0, 1'b0, 2'd0, 2'd2);

      // R2 R3 R4 R6: every combination of the three control masks
      for (int i = 0; i < 4096; i++) begin
         logic [63:0] d;
         d = {32'd0, 3'd0, (i % 7 == 3), 12'd0, 4'(i >> 8), 4'(i >> 4), 4'(i), 4'h0};
         op(2'd0, d, (i % 11 == 0), 2'(i), 2'(i >> 2));
      end

      // R5 R7 R4: every mask on each dedicated register
      for (int pass = 0; pass < 2; pass++) begin
         for (int s = 1; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
               op(2'(s), {60'd0, 4'(m)}, (pass == 1 && m % 5 == 0), 2'(m), 2'(s));
            end
         end
      end

      // R10 pulses vanish and state holds on idle cycles
      op(2'd3, 64'hF, 1'b0, 2'd1, 2'd0);
      op(2'd3, 64'hF, 1'b0, 2'd1, 2'd0);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk("R10 warn idle", 64'(warn_a), 64'd0);
         chk("R10 err idle", 64'(err_a), 64'd0);
         chk("R10 ipi hold", 64'(ipi_a), 64'(m_ipi[0]));
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule